// File: doc/BRIEF.md
# Intel HEX Record Loader

This block turns an Intel HEX text stream, delivered one ASCII character per strobe (for instance by a serial receiver), into byte writes on a memory write port. Each record is decoded as it arrives: the hex pairs are assembled into bytes, the header gives the length, the load address and the record type, and each data byte is written as soon as its second character has been seen. A two's-complement checksum is accumulated across the record and compared against the trailing byte. Records that are badly formed or that would run past the top of the address space raise a one-cycle error pulse.

Before any character is taken, the block walks the whole address space and writes 0xFF to every location, so that bytes no record touches read back as 0xFF. During this sweep the character input is ignored. Data is written before the checksum is known, so a checksum error tells the host that the image must be loaded again. An end-of-file record with a good checksum produces a one-cycle done pulse.

Top module: `hexrec_loader`

## Requirements
- R1: After reset, `fill_busy` is high and the block writes 0xFF to every address from 0 up to 2^ADDR_W-1 in ascending order, one per cycle; characters strobed while `fill_busy` is high have no effect.
- R2: While waiting for a record, ':' (0x3A) starts a record, CR (0x0D) and LF (0x0A) are ignored, and any other character raises `fmt_err` for one cycle in the cycle after its strobe.
- R3: After ':' the block reads four bytes, each as two hex characters with the high nibble first: length, address high, address low, record type; the base address is (address high << 8) | address low.
- R4: Characters 0-9, A-F and a-f are hex digits; any other character inside a record raises `fmt_err` one cycle after its strobe, and the rest of that line up to CR or LF is discarded without further errors (a ':' starts a new record at once).
- R5: For record type 0x00, data byte i is written to base+i with `mem_we` high for one cycle, in the cycle after its second character; records of any other type write nothing, and outputs stay quiet in a cycle after one with no strobe.
- R6: The 8-bit sum of length, both address bytes, type, all data bytes and the checksum byte must be 0x00; otherwise `csum_err` pulses in the cycle after the checksum's second character.
- R7: A record of type 0x01 with a correct checksum pulses `done` in the cycle after its last character; with a bad checksum there is no `done`.
- R8: A record whose base plus length exceeds 2^ADDR_W raises `fmt_err` in the cycle after the type byte's second character, writes nothing, and its remaining characters are discarded as in R4.
- R9: A record of length 0 goes straight from the type byte to the checksum byte.
- R10: At most one of `csum_err`, `fmt_err` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | 1 | Character strobe |
| ch_code | input | 8 | ASCII character |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| fill_busy | output | 1 | High while the 0xFF sweep runs |
| csum_err | output | 1 | One-cycle checksum error pulse |
| fmt_err | output | 1 | One-cycle format or range error pulse |
| done | output | 1 | One-cycle end-of-file pulse |

## Verification
A wrong field state or nibble phase shows up at the ports within one record: writes land at the wrong address or with swapped nibbles in the cycle after the affected byte, and the checksum comparison then fails at the record's end. A broken running sum appears as a spurious or missing `csum_err` one cycle after the checksum byte, and a wrong range decision shows as a missing `fmt_err` or as writes past the top address right after the type byte. Faults in the sweep show at once as a gap, repeat or non-0xFF value in the first cycles after reset.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_AHI,
        ST_ALO,
        ST_TYPE,
        ST_DATA,
        ST_SUM,
        ST_DRAIN
    } rec_state_e;

    localparam logic [7:0] CH_START = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] TYP_DATA = 8'h00;
    localparam logic [7:0] TYP_EOF  = 8'h01;

endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] value
);
    always_comb begin
        is_hex = 1'b0;
        value  = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            value  = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            value  = 4'(ch - 8'h37);
        end else if (ch >= 8'h61 && ch <= 8'h66) begin
            is_hex = 1'b1;
            value  = 4'(ch - 8'h57);
        end
    end
endmodule

// File: rtl/hexrec_fill.sv
module hexrec_fill #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              busy,
    output logic              we,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [ADDR_W-1:0] cnt;
        logic [ADDR_W-1:0] addr;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d    = fill_q;
        fill_d.we = 1'b0;
        if (fill_q.busy) begin
            fill_d.we   = 1'b1;
            fill_d.addr = fill_q.cnt;
            fill_d.cnt  = fill_q.cnt + 1'b1;
            if (fill_q.cnt == '1) begin
                fill_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '{busy: 1'b1, default: '0};
        end else begin
            fill_q <= fill_d;
        end
    end

    assign busy = fill_q.busy;
    assign we   = fill_q.we;
    assign addr = fill_q.addr;
endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
    import hexrec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic [7:0]  ch,
    input  logic        nib_ok,
    input  logic [3:0]  nib,
    output logic        we,
    output logic [15:0] waddr,
    output logic [7:0]  wdata,
    output logic        cerr,
    output logic        ferr,
    output logic        done
);
    localparam logic [16:0] SPAN = 17'(1) << ADDR_W;

    typedef struct packed {
        rec_state_e  st;
        logic        lo_nib;
        logic [3:0]  hi;
        logic [7:0]  len;
        logic [7:0]  cnt;
        logic [7:0]  typ;
        logic [7:0]  sum;
        logic [15:0] base;
        logic        we;
        logic [15:0] waddr;
        logic [7:0]  wdata;
        logic        cerr;
        logic        ferr;
        logic        done;
    } prs_t;

    prs_t prs_d, prs_q;

    logic [7:0]  byte_v;
    logic [7:0]  sum_next;
    logic [16:0] rec_end;
    logic        is_eol;

    assign byte_v   = {prs_q.hi, nib};
    assign sum_next = prs_q.sum + byte_v;
    assign rec_end  = {1'b0, prs_q.base} + {9'h0, prs_q.len};
    assign is_eol   = (ch == CH_CR) || (ch == CH_LF);

    always_comb begin
        prs_d      = prs_q;
        prs_d.we   = 1'b0;
        prs_d.cerr = 1'b0;
        prs_d.ferr = 1'b0;
        prs_d.done = 1'b0;
        if (take) begin
            unique case (prs_q.st)
                ST_HUNT, ST_DRAIN: begin
                    if (ch == CH_START) begin
                        prs_d.st     = ST_LEN;
                        prs_d.lo_nib = 1'b0;
                        prs_d.sum    = 8'h00;
                    end else if (is_eol) begin
                        prs_d.st = ST_HUNT;
                    end else if (prs_q.st == ST_HUNT) begin
                        prs_d.ferr = 1'b1;
                    end
                end
                default: begin
                    if (!nib_ok) begin
                        prs_d.ferr = 1'b1;
                        prs_d.st   = is_eol ? ST_HUNT : ST_DRAIN;
                    end else if (!prs_q.lo_nib) begin
                        prs_d.hi     = nib;
                        prs_d.lo_nib = 1'b1;
                    end else begin
                        prs_d.lo_nib = 1'b0;
                        prs_d.sum    = sum_next;
                        unique case (prs_q.st)
                            ST_LEN: begin
                                prs_d.len = byte_v;
                                prs_d.st  = ST_AHI;
                            end
                            ST_AHI: begin
                                prs_d.base[15:8] = byte_v;
                                prs_d.st         = ST_ALO;
                            end
                            ST_ALO: begin
                                prs_d.base[7:0] = byte_v;
                                prs_d.st        = ST_TYPE;
                            end
                            ST_TYPE: begin
                                prs_d.typ = byte_v;
                                prs_d.cnt = 8'h00;
                                if (rec_end > SPAN) begin
                                    prs_d.ferr = 1'b1;
                                    prs_d.st   = ST_DRAIN;
                                end else if (prs_q.len == 8'h00) begin
                                    prs_d.st = ST_SUM;
                                end else begin
                                    prs_d.st = ST_DATA;
                                end
                            end
                            ST_DATA: begin
                                if (prs_q.typ == TYP_DATA) begin
                                    prs_d.we    = 1'b1;
                                    prs_d.waddr = prs_q.base + {8'h00, prs_q.cnt};
                                    prs_d.wdata = byte_v;
                                end
                                prs_d.cnt = prs_q.cnt + 8'h01;
                                if (prs_q.cnt == prs_q.len - 8'h01) begin
                                    prs_d.st = ST_SUM;
                                end
                            end
                            ST_SUM: begin
                                if (sum_next != 8'h00) begin
                                    prs_d.cerr = 1'b1;
                                end else if (prs_q.typ == TYP_EOF) begin
                                    prs_d.done = 1'b1;
                                end
                                prs_d.st = ST_HUNT;
                            end
                            default: prs_d.st = ST_HUNT;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prs_q <= '{st: ST_HUNT, default: '0};
        end else begin
            prs_q <= prs_d;
        end
    end

    assign we    = prs_q.we;
    assign waddr = prs_q.waddr;
    assign wdata = prs_q.wdata;
    assign cerr  = prs_q.cerr;
    assign ferr  = prs_q.ferr;
    assign done  = prs_q.done;
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ch_valid,
    input  logic [7:0]        ch_code,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              fill_busy,
    output logic              csum_err,
    output logic              fmt_err,
    output logic              done
);
    logic              nib_ok;
    logic [3:0]        nib_val;
    logic              fl_busy;
    logic              fl_we;
    logic [ADDR_W-1:0] fl_addr;
    logic              pr_we;
    logic [15:0]       pr_addr;
    logic [7:0]        pr_data;

    hexrec_nibble u_nib (
        .ch     (ch_code),
        .is_hex (nib_ok),
        .value  (nib_val)
    );

    hexrec_fill #(.ADDR_W(ADDR_W)) u_fill (
        .clk  (clk),
        .rst  (rst),
        .busy (fl_busy),
        .we   (fl_we),
        .addr (fl_addr)
    );

    hexrec_parser #(.ADDR_W(ADDR_W)) u_prs (
        .clk    (clk),
        .rst    (rst),
        .take   (ch_valid && !fl_busy),
        .ch     (ch_code),
        .nib_ok (nib_ok),
        .nib    (nib_val),
        .we     (pr_we),
        .waddr  (pr_addr),
        .wdata  (pr_data),
        .cerr   (csum_err),
        .ferr   (fmt_err),
        .done   (done)
    );

    assign fill_busy = fl_busy;
    assign mem_we    = fl_we || pr_we;
    assign mem_addr  = fl_we ? fl_addr : pr_addr[ADDR_W-1:0];
    assign mem_wdata = fl_we ? 8'hFF : pr_data;
endmodule

// File: rtl/hexrec_loader_chk.sv
module hexrec_loader_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ch_valid,
    input logic [7:0]        ch_code,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              fill_busy,
    input logic              csum_err,
    input logic              fmt_err,
    input logic              done
);
    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({csum_err, fmt_err, done}));

    // R1
    fill_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(fill_busy)) |-> (mem_wdata == 8'hFF));

    // R1
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_busy && mem_we && $past(mem_we)) |->
            (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R1
    fill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fill_busy |-> !(csum_err || fmt_err || done));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(ch_valid) && !$past(fill_busy)) |->
            !(mem_we || csum_err || fmt_err || done));
endmodule

bind hexrec_loader hexrec_loader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_hexrec_loader.sv
`timescale 1ns/100ps
module tb_hexrec_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ch_valid = 1'b0;
    logic [7:0]  ch_code = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        fill_busy;
    logic        csum_err;
    logic        fmt_err;
    logic        done;

    hexrec_loader #(.ADDR_W(16)) dut (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_code(ch_code),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .fill_busy(fill_busy), .csum_err(csum_err), .fmt_err(fmt_err),
        .done(done)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit fill_phase = 1'b1;
    int fill_cnt = 0;
    int fill_err = 0;
    int f_cnt = 0;
    int c_cnt = 0;
    int d_cnt = 0;
    logic [15:0] wa[$];
    logic [7:0]  wd[$];
    logic [7:0]  dbuf[256];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (fill_phase) begin
                    if (mem_wdata != 8'hFF || mem_addr != 16'(fill_cnt)) fill_err++;
                    fill_cnt++;
                end else begin
                    wa.push_back(mem_addr);
                    wd.push_back(mem_wdata);
                end
            end
            if (fmt_err)  f_cnt++;
            if (csum_err) c_cnt++;
            if (done)     d_cnt++;
        end
    end

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    task automatic send_char(input logic [7:0] c);
        @(negedge clk);
        ch_valid = 1'b1;
        ch_code  = c;
        @(negedge clk);
        ch_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit lower);
        send_char(hexc(b[7:4], lower));
        send_char(hexc(b[3:0], lower));
    endtask

    // Sends a complete record followed by CR LF and checks writes and pulses.
    task automatic send_rec(input logic [7:0] len, input logic [15:0] addr,
                            input logic [7:0] typ, input bit corrupt,
                            input bit lower, input string tag);
        logic [7:0] sum;
        int w0, f0, c0, d0, expw, bad;
        bit oor;
        w0 = wa.size(); f0 = f_cnt; c0 = c_cnt; d0 = d_cnt;
        sum = len + addr[15:8] + addr[7:0] + typ;
        for (int i = 0; i < int'(len); i++) sum = sum + dbuf[i];
        sum = 8'h00 - sum;
        if (corrupt) sum = sum ^ 8'h21;
        send_char(8'h3A);
        send_byte(len, lower);
        send_byte(addr[15:8], lower);
        send_byte(addr[7:0], lower);
        send_byte(typ, lower);
        for (int i = 0; i < int'(len); i++) send_byte(dbuf[i], lower);
        send_byte(sum, lower);
        send_char(8'h0D);
        send_char(8'h0A);
        repeat (2) @(negedge clk);
        oor  = ({1'b0, addr} + {9'h0, len}) > 17'h10000;
        expw = (!oor && typ == 8'h00) ? int'(len) : 0;
        chk(wa.size() - w0 == expw, {tag, " R5 write count"}, wa.size() - w0, expw);
        bad = 0;
        for (int i = 0; i < expw && w0 + i < wa.size(); i++) begin
            if (wa[w0+i] != addr + 16'(i) || wd[w0+i] != dbuf[i]) bad++;
        end
        chk(bad == 0, {tag, " R3 R5 write address/data"}, bad, 0);
        chk(f_cnt - f0 == int'(oor), {tag, " R8 fmt_err"}, f_cnt - f0, int'(oor));
        chk(c_cnt - c0 == int'(!oor && corrupt), {tag, " R6 csum_err"},
            c_cnt - c0, int'(!oor && corrupt));
        chk(d_cnt - d0 == int'(!oor && !corrupt && typ == 8'h01), {tag, " R7 done"},
            d_cnt - d0, int'(!oor && !corrupt && typ == 8'h01));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w0, f0, c0, d0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(!mem_we && !csum_err && !fmt_err && !done, "R1 reset outputs quiet",
            int'({mem_we, csum_err, fmt_err, done}), 0);
        chk(fill_busy == 1'b1, "R1 fill_busy in reset", int'(fill_busy), 1);
        @(negedge clk);
        rst = 1'b0;

        // R1: a full EOF record during the sweep must be ignored
        d0 = d_cnt; f0 = f_cnt;
        send_char(8'h3A);
        send_byte(8'h00, 0); send_byte(8'h00, 0); send_byte(8'h00, 0);
        send_byte(8'h01, 0); send_byte(8'hFF, 0);
        while (fill_busy) @(negedge clk);
        repeat (2) @(negedge clk);
        fill_phase = 1'b0;
        chk(fill_cnt == 65536, "R1 sweep write count", fill_cnt, 65536);
        chk(fill_err == 0, "R1 sweep order and 0xFF data", fill_err, 0);
        chk(d_cnt == d0 && f_cnt == f0, "R1 characters ignored during sweep",
            d_cnt - d0 + f_cnt - f0, 0);

        // R2: CR/LF between records ignored, junk flagged
        w0 = wa.size(); f0 = f_cnt;
        send_char(8'h0D); send_char(8'h0A);
        repeat (2) @(negedge clk);
        chk(f_cnt == f0 && wa.size() == w0, "R2 CR LF ignored", f_cnt - f0, 0);
        send_char(8'h78);
        repeat (2) @(negedge clk);
        chk(f_cnt - f0 == 1, "R2 junk before colon", f_cnt - f0, 1);

        // R4: non-hex inside header, rest of the line discarded
        f0 = f_cnt; c0 = c_cnt; w0 = wa.size();
        send_char(8'h3A); send_char(8'h30); send_char(8'h47);
        send_char(8'h31); send_char(8'h5A); send_char(8'h0D); send_char(8'h0A);
        repeat (2) @(negedge clk);
        chk(f_cnt - f0 == 1, "R4 non-hex in record", f_cnt - f0, 1);
        chk(c_cnt == c0 && wa.size() == w0, "R4 no write or csum after bad char",
            c_cnt - c0 + wa.size() - w0, 0);

        // Directed records
        send_rec(8'd0, 16'h0000, 8'h01, 1'b0, 1'b0, "R7 eof");
        send_rec(8'd0, 16'h0000, 8'h01, 1'b1, 1'b0, "R7 eof bad sum");
        dbuf[0] = 8'hDE; dbuf[1] = 8'hAD; dbuf[2] = 8'hBE; dbuf[3] = 8'hEF;
        send_rec(8'd4, 16'h1234, 8'h00, 1'b0, 1'b0, "R3 data");
        dbuf[0] = 8'hAB; dbuf[1] = 8'hCD; dbuf[2] = 8'hEF;
        send_rec(8'd3, 16'hA0F0, 8'h00, 1'b0, 1'b1, "R4 lower case");
        send_rec(8'd0, 16'h4000, 8'h00, 1'b0, 1'b0, "R9 zero length");
        dbuf[0] = 8'h11; dbuf[1] = 8'h22;
        send_rec(8'd2, 16'h0100, 8'h02, 1'b0, 1'b0, "R5 other type");
        send_rec(8'd2, 16'h0200, 8'h00, 1'b1, 1'b0, "R6 bad sum data");
        for (int i = 0; i < 16; i++) dbuf[i] = 8'(i * 17 + 3);
        send_rec(8'd16, 16'hFFF0, 8'h00, 1'b0, 1'b0, "R8 top fits");
        send_rec(8'd16, 16'hFFF1, 8'h00, 1'b0, 1'b0, "R8 past top");
        send_rec(8'd1, 16'hFFFF, 8'h00, 1'b0, 1'b0, "R8 last byte");

        // Random records
        for (int r = 0; r < 24; r++) begin
            logic [7:0] len, typ;
            logic [15:0] addr;
            int pick;
            len = 8'($urandom_range(0, 16));
            pick = $urandom_range(0, 4);
            addr = (pick == 0) ? 16'hFFFF - 16'($urandom_range(0, 20))
                               : 16'($urandom_range(0, 65535));
            pick = $urandom_range(0, 5);
            typ = (pick == 0) ? 8'h01 : (pick == 1) ? 8'h03 : 8'h00;
            for (int i = 0; i < 16; i++) dbuf[i] = 8'($urandom_range(0, 255));
            send_rec(len, addr, typ, $urandom_range(0, 3) == 0,
                     $urandom_range(0, 1) == 1, "R5 random");
        end

        finish_run();
    end
endmodule